// File: doc/BRIEF.md
# Per-Channel Receive Fragment Reassembly Tracker

This block follows packets that arrive as a stream of receive fragments, each carrying two 32-bit status words, across up to 32 interleaved channels. For every channel it remembers whether a packet is in progress, how many bytes have been gathered so far, a running 16-bit partial checksum sum and the buffer (handle, start address, length) that the packet is being written into.

For each fragment it checks start and end framing against the channel's state and asks an external allocator for a fresh buffer when a packet starts. It computes the byte offset at which the fragment lands and checks that the packet still fits in its buffer. It then requests the data move as an address, offset and size, and frees the receive element once the move is done. At the end of a packet it either posts a completion, with an interrupt pulse, or hands the buffer back to the free pool when the fragment reports a receive error. Every fault stops the block in a sticky halted state that only a synchronous reset leaves.

The controller walks these states: IDLE (accepts a fragment) → EVAL (decode, fault and framing check) → GETBUF (start fragments only, waits for a non-zero handle) → BOUND (buffer-bound check, channel state write) → MOVE (data-move request until done) → RELEASE (element release pulse) → CLOSE (end fragments only: completion or recycle) → IDLE. The transitions EVAL→HALT, BOUND→HALT and CLOSE→HALT are taken on a fault, and HALT holds until reset.

Top module: `rx_reasm_tracker`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) every channel is idle, all four error outputs are 0, frag_ready is 1 and buf_req, xfer_req, cmpl_valid, recycle_valid and irq_pulse are 0.
- R2: The channel is frag_sw0[4:0], start-of-packet is frag_sw0[15] and end-of-packet is frag_sw0[14]. Each of the 32 channels keeps independent state, so fragments of different channels may interleave freely.
- R3: A start fragment on a channel that is already receiving, or a non-start fragment on an idle channel, sets err_proto and halts the block without moving data.
- R4: After a legal fragment the channel's receiving flag becomes start XOR old flag XOR end, so a fragment with both start and end set leaves the channel idle.
- R5: The byte count is frag_sw0[23:16]. xfer_offset equals the channel's accumulated length before the fragment (0 on a start fragment), xfer_size equals the byte count and xfer_addr equals the buffer start plus xfer_offset. The new accumulated length is the offset plus the byte count.
- R6: frag_sw1[15:0] is added, without end-around carry, into a CSUM_W-bit per-channel sum that restarts from zero on a start fragment. frag_sw1[31:16] is ignored, and the sum is reported in cmpl_csum.
- R7: If any of frag_sw0 bits 8, 9, 11 or 12 is set, err_hw is set and the block halts. This check takes precedence over the framing check.
- R8: When the buffer length is less than the new accumulated length, err_ovf is set, the block halts and no data move is requested. Equality is legal.
- R9: On a start fragment buf_req stays high until buf_gnt arrives with a non-zero buf_handle. A grant with handle 0 is ignored, and buf_start and buf_len are taken with the accepted handle.
- R10: On an end fragment with frag_sw0[10] clear and done_full low, cmpl_valid and irq_pulse are high for exactly one cycle, with the channel, total length, checksum and buffer handle on the cmpl_* outputs.
- R11: On an end fragment with frag_sw0[10] set, recycle_valid pulses for one cycle with the buffer handle, and there is no completion and no interrupt, whatever the level of done_full.
- R12: The element id is frag_sw0[30:24]. elem_release pulses with that id in the cycle after xfer_done is seen while xfer_req is high.
- R13: A completion that meets done_full high sets err_done_ovf and halts. It does not issue cmpl_valid or irq_pulse.
- R14: The error outputs are sticky and frag_ready stays low while any of them is set. Only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frag_valid | input | 1 | Fragment status words are present |
| frag_ready | output | 1 | Block accepts a fragment this cycle |
| frag_sw0 | input | 32 | First status word (channel, framing, count, element, error flags) |
| frag_sw1 | input | 32 | Second status word (partial checksum in low half) |
| buf_req | output | 1 | Request for a free buffer |
| buf_gnt | input | 1 | Free buffer offered |
| buf_handle | input | ADDR_W | Offered buffer handle (0 means none) |
| buf_start | input | ADDR_W | Offered buffer start address |
| buf_len | input | LEN_W | Offered buffer length in bytes |
| xfer_req | output | 1 | Data-move request |
| xfer_done | input | 1 | Data move finished |
| xfer_addr | output | ADDR_W | Destination address of the fragment |
| xfer_offset | output | LEN_W | Byte offset of the fragment inside the packet |
| xfer_size | output | 8 | Fragment byte count |
| elem_release | output | 1 | Receive element may be reused |
| elem_id | output | 7 | Element being released |
| done_full | input | 1 | Completion queue has no room |
| cmpl_valid | output | 1 | Completion strobe |
| cmpl_chan | output | CH_W | Channel of the completed packet |
| cmpl_len | output | LEN_W | Total packet length |
| cmpl_csum | output | CSUM_W | Summed partial checksum |
| cmpl_handle | output | ADDR_W | Buffer holding the packet |
| irq_pulse | output | 1 | Interrupt pulse for a completion |
| recycle_valid | output | 1 | Buffer returned to the free pool |
| recycle_handle | output | ADDR_W | Returned buffer handle |
| err_hw | output | 1 | Sticky fatal hardware flag seen |
| err_proto | output | 1 | Sticky framing violation |
| err_ovf | output | 1 | Sticky buffer overflow |
| err_done_ovf | output | 1 | Sticky completion-queue overflow |

## Verification
A corrupted receiving flag shows at the ports the next time that channel sees a fragment: a legal stream then ends in err_proto two cycles after the fragment is accepted, instead of a data move. A wrong stored length or sum is invisible until the channel's next fragment, where it shows in xfer_offset, or until end of packet, where it shows in cmpl_len and cmpl_csum. The bench therefore interleaves several channels and lets each packet close several fragments after its state was written, so that stale or cross-channel state is caught. A lost buffer descriptor shows as a wrong xfer_addr on a continuation fragment or a wrong completion or recycle handle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    // Field positions inside the first status word
    localparam int SOP_BIT   = 15;
    localparam int EOP_BIT   = 14;
    localparam int RXERR_BIT = 10;
    localparam int CNT_LSB   = 16;
    localparam int CNT_W     = 8;
    localparam int ELEM_LSB  = 24;
    localparam int ELEM_W    = 7;
    localparam int PSUM_W    = 16;
    // Fatal hardware flags: bits 8, 9, 11, 12
    localparam logic [31:0] HW_FAULT_MASK = 32'h0000_1B00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_GETBUF,
        ST_BOUND,
        ST_MOVE,
        ST_RELEASE,
        ST_CLOSE,
        ST_HALT
    } rxr_state_e;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic              rxerr;
        logic              hw_fault;
        logic [ELEM_W-1:0] elem;
        logic [CNT_W-1:0]  cnt;
        logic [PSUM_W-1:0] psum;
    } rxr_frag_t;

endpackage

// File: rtl/rxr_status_decode.sv
module rxr_status_decode
    import rxr_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  logic [31:0]     sw0,
    input  logic [31:0]     sw1,
    output rxr_frag_t       frag,
    output logic [CH_W-1:0] chan
);

    logic unused_sw1_hi;

    always_comb begin
        frag.sop      = sw0[SOP_BIT];
        frag.eop      = sw0[EOP_BIT];
        frag.rxerr    = sw0[RXERR_BIT];
        frag.hw_fault = |(sw0 & HW_FAULT_MASK);
        frag.elem     = sw0[ELEM_LSB +: ELEM_W];
        frag.cnt      = sw0[CNT_LSB +: CNT_W];
        frag.psum     = sw1[PSUM_W-1:0];
    end

    assign chan          = sw0[CH_W-1:0];
    assign unused_sw1_hi = ^sw1[31:PSUM_W];

endmodule

// File: rtl/rxr_chan_table.sv
module rxr_chan_table #(
    parameter int CH_W   = 5,
    parameter int LEN_W  = 16,
    parameter int CSUM_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   rd_chan,
    output logic              rd_busy,
    output logic [LEN_W-1:0]  rd_len,
    output logic [CSUM_W-1:0] rd_csum,
    output logic [ADDR_W-1:0] rd_handle,
    output logic [ADDR_W-1:0] rd_start,
    output logic [LEN_W-1:0]  rd_blen,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic              wr_busy,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [CSUM_W-1:0] wr_csum,
    input  logic [ADDR_W-1:0] wr_handle,
    input  logic [ADDR_W-1:0] wr_start,
    input  logic [LEN_W-1:0]  wr_blen
);

    localparam int NCH = 1 << CH_W;

    logic              busy_q   [NCH];
    logic [LEN_W-1:0]  len_q    [NCH];
    logic [CSUM_W-1:0] csum_q   [NCH];
    logic [ADDR_W-1:0] handle_q [NCH];
    logic [ADDR_W-1:0] start_q  [NCH];
    logic [LEN_W-1:0]  blen_q   [NCH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n) begin
                busy_q[i]   <= 1'b0;
                len_q[i]    <= '0;
                csum_q[i]   <= '0;
                handle_q[i] <= '0;
                start_q[i]  <= '0;
                blen_q[i]   <= '0;
            end else if (wr_en && (wr_chan == CH_W'(i))) begin
                busy_q[i]   <= wr_busy;
                len_q[i]    <= wr_len;
                csum_q[i]   <= wr_csum;
                handle_q[i] <= wr_handle;
                start_q[i]  <= wr_start;
                blen_q[i]   <= wr_blen;
            end
        end
    end

    assign rd_busy   = busy_q[rd_chan];
    assign rd_len    = len_q[rd_chan];
    assign rd_csum   = csum_q[rd_chan];
    assign rd_handle = handle_q[rd_chan];
    assign rd_start  = start_q[rd_chan];
    assign rd_blen   = blen_q[rd_chan];

endmodule

// File: rtl/rx_reasm_tracker.sv
module rx_reasm_tracker
    import rxr_pkg::*;
#(
    parameter int CH_W   = 5,
    parameter int LEN_W  = 16,
    parameter int CSUM_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frag_valid,
    output logic              frag_ready,
    input  logic [31:0]       frag_sw0,
    input  logic [31:0]       frag_sw1,
    output logic              buf_req,
    input  logic              buf_gnt,
    input  logic [ADDR_W-1:0] buf_handle,
    input  logic [ADDR_W-1:0] buf_start,
    input  logic [LEN_W-1:0]  buf_len,
    output logic              xfer_req,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_offset,
    output logic [7:0]        xfer_size,
    output logic              elem_release,
    output logic [6:0]        elem_id,
    input  logic              done_full,
    output logic              cmpl_valid,
    output logic [CH_W-1:0]   cmpl_chan,
    output logic [LEN_W-1:0]  cmpl_len,
    output logic [CSUM_W-1:0] cmpl_csum,
    output logic [ADDR_W-1:0] cmpl_handle,
    output logic              irq_pulse,
    output logic              recycle_valid,
    output logic [ADDR_W-1:0] recycle_handle,
    output logic              err_hw,
    output logic              err_proto,
    output logic              err_ovf,
    output logic              err_done_ovf
);

    rxr_state_e state_q, state_d;

    logic [31:0]       sw0_q, sw1_q;
    rxr_frag_t         frag;
    logic [CH_W-1:0]   chan;

    logic              rd_busy;
    logic [LEN_W-1:0]  rd_len, rd_blen;
    logic [CSUM_W-1:0] rd_csum;
    logic [ADDR_W-1:0] rd_handle, rd_start;

    logic [LEN_W-1:0]  off_q, len_q, blen_q;
    logic [CSUM_W-1:0] csum_q;
    logic [ADDR_W-1:0] handle_q, start_q;
    logic              busy_nx_q;
    logic              e_hw_q, e_proto_q, e_ovf_q, e_dfull_q;

    logic              framing_bad, grant_ok, too_long, dfull_bad, tbl_we;
    logic [LEN_W-1:0]  base_len;
    logic [CSUM_W-1:0] base_csum;

    rxr_status_decode #(.CH_W(CH_W)) u_decode (
        .sw0  (sw0_q),
        .sw1  (sw1_q),
        .frag (frag),
        .chan (chan)
    );

    rxr_chan_table #(
        .CH_W   (CH_W),
        .LEN_W  (LEN_W),
        .CSUM_W (CSUM_W),
        .ADDR_W (ADDR_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_chan   (chan),
        .rd_busy   (rd_busy),
        .rd_len    (rd_len),
        .rd_csum   (rd_csum),
        .rd_handle (rd_handle),
        .rd_start  (rd_start),
        .rd_blen   (rd_blen),
        .wr_en     (tbl_we),
        .wr_chan   (chan),
        .wr_busy   (busy_nx_q),
        .wr_len    (len_q),
        .wr_csum   (csum_q),
        .wr_handle (handle_q),
        .wr_start  (start_q),
        .wr_blen   (blen_q)
    );

    // Conditions evaluated in the states that use them
    assign framing_bad = (frag.sop == rd_busy);
    assign grant_ok    = buf_gnt && (buf_handle != '0);
    assign too_long    = (blen_q < len_q);
    assign dfull_bad   = !frag.rxerr && done_full;
    assign tbl_we      = (state_q == ST_BOUND) && !too_long;
    assign base_len    = frag.sop ? '0 : rd_len;
    assign base_csum   = frag.sop ? '0 : rd_csum;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (frag_valid) state_d = ST_EVAL;
            ST_EVAL: begin
                if (frag.hw_fault || framing_bad) state_d = ST_HALT;
                else if (frag.sop)                state_d = ST_GETBUF;
                else                              state_d = ST_BOUND;
            end
            ST_GETBUF:  if (grant_ok) state_d = ST_BOUND;
            ST_BOUND:   state_d = too_long ? ST_HALT : ST_MOVE;
            ST_MOVE:    if (xfer_done) state_d = ST_RELEASE;
            ST_RELEASE: state_d = frag.eop ? ST_CLOSE : ST_IDLE;
            ST_CLOSE:   state_d = dfull_bad ? ST_HALT : ST_IDLE;
            ST_HALT:    state_d = ST_HALT;
            default:    state_d = ST_HALT;
        endcase
    end

    // Working registers and sticky errors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw0_q     <= '0;
            sw1_q     <= '0;
            off_q     <= '0;
            len_q     <= '0;
            csum_q    <= '0;
            blen_q    <= '0;
            handle_q  <= '0;
            start_q   <= '0;
            busy_nx_q <= 1'b0;
            e_hw_q    <= 1'b0;
            e_proto_q <= 1'b0;
            e_ovf_q   <= 1'b0;
            e_dfull_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (frag_valid) begin
                        sw0_q <= frag_sw0;
                        sw1_q <= frag_sw1;
                    end
                end
                ST_EVAL: begin
                    off_q     <= base_len;
                    len_q     <= base_len + LEN_W'(frag.cnt);
                    csum_q    <= base_csum + CSUM_W'(frag.psum);
                    busy_nx_q <= frag.sop ^ rd_busy ^ frag.eop;
                    if (!frag.sop) begin
                        handle_q <= rd_handle;
                        start_q  <= rd_start;
                        blen_q   <= rd_blen;
                    end
                    if (frag.hw_fault)    e_hw_q    <= 1'b1;
                    else if (framing_bad) e_proto_q <= 1'b1;
                end
                ST_GETBUF: begin
                    if (grant_ok) begin
                        handle_q <= buf_handle;
                        start_q  <= buf_start;
                        blen_q   <= buf_len;
                    end
                end
                ST_BOUND:   if (too_long) e_ovf_q <= 1'b1;
                ST_CLOSE:   if (dfull_bad) e_dfull_q <= 1'b1;
                ST_MOVE, ST_RELEASE, ST_HALT: ;
                default: ;
            endcase
        end
    end

    // Strobes per state
    always_comb begin
        frag_ready    = 1'b0;
        buf_req       = 1'b0;
        xfer_req      = 1'b0;
        elem_release  = 1'b0;
        cmpl_valid    = 1'b0;
        irq_pulse     = 1'b0;
        recycle_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:    frag_ready   = 1'b1;
            ST_GETBUF:  buf_req      = 1'b1;
            ST_MOVE:    xfer_req     = 1'b1;
            ST_RELEASE: elem_release = 1'b1;
            ST_CLOSE: begin
                recycle_valid = frag.rxerr;
                cmpl_valid    = !frag.rxerr && !done_full;
                irq_pulse     = !frag.rxerr && !done_full;
            end
            ST_EVAL, ST_BOUND, ST_HALT: ;
            default: ;
        endcase
    end

    assign xfer_addr      = start_q + ADDR_W'(off_q);
    assign xfer_offset    = off_q;
    assign xfer_size      = frag.cnt;
    assign elem_id        = frag.elem;
    assign cmpl_chan      = chan;
    assign cmpl_len       = len_q;
    assign cmpl_csum      = csum_q;
    assign cmpl_handle    = handle_q;
    assign recycle_handle = handle_q;
    assign err_hw         = e_hw_q;
    assign err_proto      = e_proto_q;
    assign err_ovf        = e_ovf_q;
    assign err_done_ovf   = e_dfull_q;

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker (
    input logic clk,
    input logic rst_n,
    input logic frag_ready,
    input logic buf_req,
    input logic xfer_req,
    input logic xfer_done,
    input logic elem_release,
    input logic done_full,
    input logic cmpl_valid,
    input logic irq_pulse,
    input logic recycle_valid,
    input logic err_hw,
    input logic err_proto,
    input logic err_ovf,
    input logic err_done_ovf
);

    AST_HALT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_hw || err_proto || err_ovf || err_done_ovf) |-> !frag_ready); // R14
    AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_proto |=> err_proto); // R3
    AST_HW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_hw |=> err_hw); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |=> err_ovf); // R8
    AST_DONE_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_done_ovf |=> err_done_ovf); // R13
    AST_CMPL_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |-> !done_full); // R13
    AST_IRQ_WITH_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> cmpl_valid); // R10
    AST_RECYCLE_NO_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
        recycle_valid |-> (!cmpl_valid && !irq_pulse)); // R11
    AST_RELEASE_AFTER_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        elem_release |-> $past(xfer_req && xfer_done)); // R12
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frag_ready, buf_req, xfer_req, elem_release})); // R9

endmodule

bind rx_reasm_tracker rxr_checker chk_i (.*);

// File: tb/rx_reasm_tracker_tb.sv
`timescale 1ns/1ps
module rx_reasm_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frag_valid = 1'b0;
    logic        frag_ready;
    logic [31:0] frag_sw0 = '0, frag_sw1 = '0;
    logic        buf_req, buf_gnt = 1'b0;
    logic [31:0] buf_handle = '0, buf_start = '0;
    logic [15:0] buf_len = '0;
    logic        xfer_req, xfer_done = 1'b0;
    logic [31:0] xfer_addr;
    logic [15:0] xfer_offset;
    logic [7:0]  xfer_size;
    logic        elem_release;
    logic [6:0]  elem_id;
    logic        done_full = 1'b0;
    logic        cmpl_valid;
    logic [4:0]  cmpl_chan;
    logic [15:0] cmpl_len;
    logic [31:0] cmpl_csum, cmpl_handle;
    logic        irq_pulse, recycle_valid;
    logic [31:0] recycle_handle;
    logic        err_hw, err_proto, err_ovf, err_done_ovf;

    always #2 clk = ~clk;

    rx_reasm_tracker dut_i (.*);

    int nvec = 0, nfail = 0;
    bit finished = 0;

    // captures of one fragment run
    bit          c_breq, c_rereq, c_xfer, c_rel, c_cmpl, c_irq, c_rec;
    logic [31:0] c_addr, c_chandle, c_csum, c_rhandle;
    logic [15:0] c_off, c_len;
    logic [7:0]  c_size;
    logic [6:0]  c_elem;
    logic [4:0]  c_chan;

    function automatic logic [31:0] mk0(int elem, int cnt, bit sop, bit eop, bit rxe, int ch);
        return (32'(elem & 'h7f) << 24) | (32'(cnt & 'hff) << 16) | (32'(sop) << 15)
             | (32'(eop) << 14) | (32'(rxe) << 10) | 32'(ch & 'h1f);
    endfunction

    typedef struct packed {
        logic [31:0] sw0;
        logic [15:0] psum;
        logic [15:0] off;
        logic [1:0]  fin;   // 0 none, 1 completion, 2 recycle
        logic [15:0] tlen;
        logic [31:0] tsum;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{mk0(1,  'h40, 1, 0, 0, 3),  16'h0011, 16'h0000, 2'd0, 16'h0000, 32'h0000_0000},
        '{mk0(2,  'h20, 1, 1, 0, 7),  16'h0005, 16'h0000, 2'd1, 16'h0020, 32'h0000_0005},
        '{mk0(3,  'h40, 0, 0, 0, 3),  16'hFFFF, 16'h0040, 2'd0, 16'h0000, 32'h0000_0000},
        '{mk0(4,  'h10, 1, 0, 0, 9),  16'h0001, 16'h0000, 2'd0, 16'h0000, 32'h0000_0000},
        '{mk0(5,  'h08, 0, 1, 0, 3),  16'h8000, 16'h0080, 2'd1, 16'h0088, 32'h0001_8010},
        '{mk0(6,  'h10, 0, 1, 1, 9),  16'h0002, 16'h0010, 2'd2, 16'h0000, 32'h0000_0000},
        '{mk0(7,  'h30, 1, 1, 0, 7),  16'h0003, 16'h0000, 2'd1, 16'h0030, 32'h0000_0003},
        '{mk0(8,  'h40, 1, 0, 0, 31), 16'h0020, 16'h0000, 2'd0, 16'h0000, 32'h0000_0000},
        '{mk0(9,  'h01, 1, 1, 0, 0),  16'hABCD, 16'h0000, 2'd1, 16'h0001, 32'h0000_ABCD},
        '{mk0(10, 'h40, 0, 1, 0, 31), 16'h0010, 16'h0040, 2'd1, 16'h0080, 32'h0000_0030}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        done_full = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_frag(input logic [31:0] s0, input logic [31:0] s1,
                            input logic [31:0] bh, input logic [31:0] bs,
                            input logic [15:0] bl, input bit zero_first, input bit dfull);
        bit zsent = 0;
        c_breq = 0; c_rereq = 0; c_xfer = 0; c_rel = 0; c_cmpl = 0; c_irq = 0; c_rec = 0;
        done_full = dfull;
        for (int w = 0; w < 20 && !frag_ready; w++) @(negedge clk);
        frag_sw0 = s0; frag_sw1 = s1; frag_valid = 1'b1;
        @(negedge clk);
        frag_valid = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (buf_req) begin
                c_breq = 1;
                if (zero_first && !zsent) begin
                    buf_handle = '0; zsent = 1;
                end else begin
                    if (zsent) c_rereq = 1;
                    buf_handle = bh;
                end
                buf_start = bs; buf_len = bl; buf_gnt = 1'b1;
            end else buf_gnt = 1'b0;
            if (xfer_req) begin
                c_xfer = 1; c_addr = xfer_addr; c_off = xfer_offset; c_size = xfer_size;
                xfer_done = 1'b1;
            end else xfer_done = 1'b0;
            if (elem_release) begin c_rel = 1; c_elem = elem_id; end
            if (cmpl_valid) begin
                c_cmpl = 1; c_chan = cmpl_chan; c_len = cmpl_len;
                c_csum = cmpl_csum; c_chandle = cmpl_handle;
            end
            if (irq_pulse) c_irq = 1;
            if (recycle_valid) begin c_rec = 1; c_rhandle = recycle_handle; end
            if (frag_ready || err_hw || err_proto || err_ovf || err_done_ovf) break;
            @(negedge clk);
        end
        buf_gnt = 1'b0; xfer_done = 1'b0;
    endtask

    task automatic chk_errs(input string tag, input logic [3:0] exp);
        chk(tag, {err_hw, err_proto, err_ovf, err_done_ovf}, exp);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 frag_ready after reset", frag_ready, 1);
        chk("R1 errors after reset", {err_hw, err_proto, err_ovf, err_done_ovf}, 0);
        chk("R1 strobes after reset", {buf_req, xfer_req, cmpl_valid, recycle_valid, irq_pulse}, 0);

        // Interleaved vector table (R2 R4 R5 R6 R10 R11 R12)
        for (int v = 0; v < NV; v++) begin
            logic [4:0] ch;
            ch = VECS[v].sw0[4:0];
            run_frag(VECS[v].sw0, 32'hDEAD_0000 | 32'(VECS[v].psum),
                     32'h100 + 32'(ch), (32'(ch) + 1) << 12, 16'h0200, 0, 0);
            chk("R5 move requested", c_xfer, 1);
            chk("R5 xfer_offset", c_off, VECS[v].off);
            chk("R5 xfer_addr", c_addr, ((32'(ch) + 1) << 12) + 32'(VECS[v].off));
            chk("R5 xfer_size", c_size, VECS[v].sw0[23:16]);
            chk("R12 element released", {c_rel, c_elem}, {1'b1, 7'(v + 1)});
            chk("R2 no error on legal interleave", {err_hw, err_proto, err_ovf, err_done_ovf}, 0);
            if (VECS[v].fin == 2'd1) begin
                chk("R10 completion and irq", {c_cmpl, c_irq, c_rec}, 3'b110);
                chk("R10 completion channel", c_chan, ch);
                chk("R5 completion length", c_len, VECS[v].tlen);
                chk("R6 completion checksum", c_csum, VECS[v].tsum);
                chk("R10 completion handle", c_chandle, 32'h100 + 32'(ch));
            end else if (VECS[v].fin == 2'd2) begin
                chk("R11 recycle only", {c_cmpl, c_irq, c_rec}, 3'b001);
                chk("R11 recycle handle", c_rhandle, 32'h100 + 32'(ch));
            end else begin
                chk("R4 no end action mid packet", {c_cmpl, c_irq, c_rec}, 0);
            end
        end

        // R9 zero handle ignored; R8 equality legal
        run_frag(mk0(11, 'h40, 1, 1, 0, 5), 32'h7, 32'h105, 32'h6000, 16'h0040, 1, 0);
        chk("R9 request held after zero handle", c_rereq, 1);
        chk("R9 buffer start from accepted grant", c_addr, 32'h6000);
        chk("R9 completion handle from accepted grant", c_chandle, 32'h105);
        chk("R8 exact fit accepted", {err_ovf, c_cmpl}, 2'b01);

        // R4 R3 single-fragment packet left ch0 idle: continuation is illegal
        run_frag(mk0(12, 'h10, 0, 1, 0, 0), 32'h1, 32'h0, 32'h0, 16'h0, 0, 0);
        chk_errs("R3 continuation on idle channel", 4'b0100);
        chk("R3 no move on framing error", c_xfer, 0);
        repeat (4) @(negedge clk);
        chk("R14 halted stays not ready", frag_ready, 0);
        do_reset();
        chk_errs("R14 reset clears errors", 4'b0000);
        chk("R14 ready after reset", frag_ready, 1);

        // R3 double start
        run_frag(mk0(13, 'h10, 1, 0, 0, 4), 32'h1, 32'h104, 32'h5000, 16'h0200, 0, 0);
        run_frag(mk0(14, 'h10, 1, 0, 0, 4), 32'h1, 32'h204, 32'h9000, 16'h0200, 0, 0);
        chk_errs("R3 start on receiving channel", 4'b0100);
        chk("R3 no buffer requested on error", c_breq, 0);
        do_reset();

        // R8 overflow on start fragment
        run_frag(mk0(15, 'h40, 1, 0, 0, 6), 32'h1, 32'h106, 32'h7000, 16'h003F, 0, 0);
        chk_errs("R8 overflow on start", 4'b0010);
        chk("R8 no move on overflow", c_xfer, 0);
        do_reset();

        // R8 overflow on continuation
        run_frag(mk0(16, 'h40, 1, 0, 0, 6), 32'h1, 32'h106, 32'h7000, 16'h0060, 0, 0);
        chk_errs("R8 first fragment fits", 4'b0000);
        run_frag(mk0(17, 'h40, 0, 0, 0, 6), 32'h1, 32'h0, 32'h0, 16'h0, 0, 0);
        chk_errs("R8 overflow on continuation", 4'b0010);
        chk("R8 no move on continuation overflow", c_xfer, 0);
        do_reset();

        // R7 each fatal flag, even on an otherwise illegal fragment
        for (int k = 0; k < 4; k++) begin
            int b;
            b = (k == 0) ? 8 : (k == 1) ? 9 : (k == 2) ? 11 : 12;
            run_frag(mk0(18, 'h10, 0, 0, 0, 1) | (32'h1 << b), 32'h1, 32'h101, 32'h2000, 16'h0200, 0, 0);
            chk_errs("R7 fatal flag halts", 4'b1000);
            chk("R7 no move on fatal flag", c_xfer, 0);
            do_reset();
        end

        // R13 completion into full queue
        run_frag(mk0(19, 'h20, 1, 1, 0, 2), 32'h1, 32'h102, 32'h3000, 16'h0200, 0, 1);
        chk("R13 no completion or irq when full", {c_cmpl, c_irq}, 0);
        chk_errs("R13 done overflow raised", 4'b0001);
        repeat (4) @(negedge clk);
        chk("R14 done overflow sticky", {err_done_ovf, frag_ready}, 2'b10);
        do_reset();
        chk_errs("R14 reset clears done overflow", 4'b0000);

        // R11 recycle ignores done_full
        run_frag(mk0(20, 'h20, 1, 1, 1, 8), 32'h1, 32'h108, 32'h4000, 16'h0200, 0, 1);
        chk("R11 recycle with full queue", {c_rec, c_cmpl, c_irq}, 3'b100);
        chk("R11 recycle handle", c_rhandle, 32'h108);
        chk_errs("R11 no error on recycle", 4'b0000);

        done_full = 1'b0;
        finished = 1;
        summary();
        $finish;
    end

endmodule